// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the device side of the serial read port of a 12-bit converter, written as a synthesizable peer against which serial masters can be tested. A parallel sample word is presented on `sample_i`. The block watches an active-low chip-select and a serial clock and drives one data bit with a separate output enable. The output enable low stands for high impedance.

All logic runs on a fast system clock. Chip-select and the serial clock are brought in through synchronizers, and their edges are found by comparing each synchronized value with its previous value. A frame has a fixed shape:
- The output stays undriven through the first falling serial-clock edge.
- It drives a zero null bit.
- It drives the word most-significant bit first.
- If clocks continue, it sends the word again least-significant bit first, starting from bit 1.
- After that repeat it goes undriven again.

The mode with the serial clock idling low and the mode with it idling high both work, because only falling edges move the sequence.

The sequencer has seven named states:
- `ST_IDLE`: chip-select high.
- `ST_ARMED`: selected, no falling edge seen yet.
- `ST_LEAD`: one falling edge seen.
- `ST_NULL`: driving the null bit.
- `ST_MSB`: first pass, downward.
- `ST_LSB`: repeat pass, upward.
- `ST_DONE`: tail, undriven.

Its transitions are:
- Any state goes to `ST_IDLE` when chip-select is high.
- `ST_IDLE` goes to `ST_ARMED` when chip-select is low, and the sample is captured at this step.
- On each falling edge: `ST_ARMED` goes to `ST_LEAD`, `ST_LEAD` goes to `ST_NULL`, and `ST_NULL` goes to `ST_MSB` at index 11.
- In `ST_MSB`, each falling edge steps the index down by one. At index 0 a falling edge moves to `ST_LSB` at index 1.
- In `ST_LSB`, each falling edge steps the index up by one. At index 11 a falling edge moves to `ST_DONE`.

Top module: `adc_sdo_sequencer`

## Requirements
- R1: While chip-select (`cs_n_i`) is high, `sdo_oe_o` is 0, whatever the serial clock does.
- R2: After chip-select goes low, `sdo_oe_o` stays 0 until the second falling serial-clock edge of the frame.
- R3: The data output and its enable change only in response to a falling serial-clock edge or a chip-select change. Rising edges leave them unchanged.
- R4: Falling edge 2 of a frame drives `sdo_oe_o`=1 with `sdo_o`=0 (the null bit). Falling edge 3 drives sample bit 11.
- R5: Falling edge n, for n from 3 to 14, drives sample bit 14-n, so bit 0 appears at edge 14.
- R6: Falling edge n, for n from 15 to 25, drives sample bit n-14: a least-significant-first repeat that starts at bit 1 and ends with bit 11.
- R7: The sample is captured when chip-select goes low. Changes on `sample_i` later in the frame have no effect on the bits driven in that frame.
- R8: From falling edge 26 onward, `sdo_oe_o` is 0 until chip-select goes high.
- R9: The sequence is the same whether the serial clock idles low or idles high between frames.
- R10: Chip-select going high at any point ends the frame. The next frame starts again at edge 1. If a falling edge arrives in the same cycle as the chip-select rise, the end of the frame takes priority and that edge is not counted.
- R11: After reset, `sdo_oe_o` and `sdo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 12 | Parallel sample word, captured when chip-select falls |
| cs_n_i | input | 1 | Active-low chip-select, asynchronous to `clk` |
| sclk_i | input | 1 | Serial clock from the master, asynchronous to `clk` |
| sdo_o | output | 1 | Serial data bit, valid while `sdo_oe_o` is 1 |
| sdo_oe_o | output | 1 | Output enable; 0 means the data pin is high impedance |

## Verification
Two events can land in the same system-clock cycle: a falling serial-clock edge that would advance the sequence, and a chip-select rise that ends the frame. The bench provokes this by lowering the serial clock and raising chip-select at the same instant in the middle of a frame. Both inputs then pass through equal synchronizer depths and reach the sequencer together. The result is judged at the pins: the enable must drop and stay low. The following frame must show the undriven lead edge, the null bit on edge 2 and bit 11 on edge 3, which shows that the colliding edge was not counted.

// File: rtl/sdo_seq_pkg.sv
`timescale 1ns/1ps
package sdo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_LEAD  = 3'd2,
        ST_NULL  = 3'd3,
        ST_MSB   = 3'd4,
        ST_LSB   = 3'd5,
        ST_DONE  = 3'd6
    } sdo_state_e;

endpackage

// File: rtl/sdo_edge_sync.sv
`timescale 1ns/1ps
// Brings one asynchronous level into the clk domain and flags its edges.
module sdo_edge_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= RESET_VAL;
                end else begin
                    chain_q <= async_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RESET_VAL;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/sdo_bit_mux.sv
`timescale 1ns/1ps
// Picks the bit to present from the captured word, or the null bit.
module sdo_bit_mux #(
    parameter int DATA_W = 12,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              null_i,
    output logic              bit_o
);

    logic [DATA_W-1:0] onehot;

    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_dec
            assign onehot[g] = (idx_i == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        if (null_i) begin
            bit_o = 1'b0;
        end else begin
            bit_o = |(word_i & onehot);
        end
    end

endmodule

// File: rtl/sdo_frame_fsm.sv
`timescale 1ns/1ps
// Frame sequencer: counts falling serial-clock edges while selected.
module sdo_frame_fsm
    import sdo_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi_i,
    input  logic              sclk_fall_i,
    input  logic              sclk_rise_i,
    input  logic [DATA_W-1:0] sample_i,
    output sdo_state_e        state_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] word_o,
    output logic              drive_o,
    output logic              null_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

    sdo_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] word_q;
    logic              capture;

    // State register, index and captured word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (capture) begin
                word_q <= sample_i;
            end
        end
    end

    // Next-state logic: deselect has priority over every edge
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        capture = 1'b0;
        if (cs_hi_i) begin
            state_d = ST_IDLE;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_ARMED;
                    idx_d   = '0;
                    capture = 1'b1;
                end
                ST_ARMED: begin
                    if (sclk_fall_i) state_d = ST_LEAD;
                end
                ST_LEAD: begin
                    if (sclk_fall_i) state_d = ST_NULL;
                end
                ST_NULL: begin
                    if (sclk_fall_i) begin
                        state_d = ST_MSB;
                        idx_d   = TOP_IDX;
                    end
                end
                ST_MSB: begin
                    if (sclk_fall_i) begin
                        if (idx_q == '0) begin
                            state_d = ST_LSB;
                            idx_d   = ONE_IDX;
                        end else begin
                            idx_d = idx_q - ONE_IDX;
                        end
                    end
                end
                ST_LSB: begin
                    if (sclk_fall_i) begin
                        if (idx_q == TOP_IDX) begin
                            state_d = ST_DONE;
                            idx_d   = '0;
                        end else begin
                            idx_d = idx_q + ONE_IDX;
                        end
                    end
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
                default: begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        drive_o = 1'b0;
        null_o  = 1'b0;
        unique case (state_q)
            ST_NULL: begin
                drive_o = 1'b1;
                null_o  = 1'b1;
            end
            ST_MSB, ST_LSB: begin
                drive_o = 1'b1;
            end
            default: begin
                drive_o = 1'b0;
                null_o  = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign word_o  = word_q;

    // R10: deselect always lands in idle
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi_i |=> (state_q == ST_IDLE));

    // R7: captured word frozen once a frame is open
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(word_q));

    // R6: the repeat pass begins at bit 1
    p_lsb_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MSB && idx_q == '0 && sclk_fall_i && !cs_hi_i)
        |=> (state_q == ST_LSB && idx_q == ONE_IDX));

    // R3: with no falling edge and no deselect, the sequence does not move
    p_hold_no_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall_i && !cs_hi_i && state_q != ST_IDLE)
        |=> ($stable(state_q) && $stable(idx_q)));

    // R9: a rising edge alone never advances the sequence
    p_rise_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise_i && !cs_hi_i && state_q != ST_IDLE) |=> $stable(idx_q));

    // R8: the tail state holds until deselect
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !cs_hi_i) |=> (state_q == ST_DONE));

endmodule

// File: rtl/adc_sdo_sequencer.sv
`timescale 1ns/1ps
module adc_sdo_sequencer
    import sdo_seq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int IDX_W = $clog2(DATA_W);

    logic              cs_hi, cs_rise, cs_fall;
    logic              sclk_lvl, sclk_rise, sclk_fall;
    sdo_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word;
    logic              drive, null_bit, mux_bit;

    sdo_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cs_n_i),
        .level_o (cs_hi),
        .rise_o  (cs_rise),
        .fall_o  (cs_fall)
    );

    sdo_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sclk_i),
        .level_o (sclk_lvl),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    sdo_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_hi_i     (cs_hi),
        .sclk_fall_i (sclk_fall),
        .sclk_rise_i (sclk_rise),
        .sample_i    (sample_i),
        .state_o     (state),
        .idx_o       (idx),
        .word_o      (word),
        .drive_o     (drive),
        .null_o      (null_bit)
    );

    sdo_bit_mux #(.DATA_W(DATA_W)) u_mux (
        .word_i (word),
        .idx_i  (idx),
        .null_i (null_bit),
        .bit_o  (mux_bit)
    );

    assign sdo_oe_o = drive;
    assign sdo_o    = drive & mux_bit;

    // R1: deselected means undriven one cycle later
    p_hiz_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !sdo_oe_o);

    // R10: a deselect edge clears any open frame
    p_rise_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_IDLE && !sdo_oe_o));

    // R2: the select edge opens a frame undriven
    p_select_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (state == ST_ARMED && !sdo_oe_o));

    // R4: second falling edge presents a driven zero
    p_null_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && sclk_fall && !cs_hi) |=> (sdo_oe_o && !sdo_o));

    // R5: third falling edge presents the top bit of the captured word
    p_msb_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NULL && sclk_fall && !cs_hi)
        |=> (sdo_oe_o && sdo_o == word[DATA_W-1]));

    // R3: pins hold between falling edges while selected
    p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_hi && state != ST_IDLE && sclk_lvl == $past(sclk_lvl))
        |=> ($stable(sdo_oe_o) && $stable(sdo_o)));

endmodule

// File: tb/adc_sdo_sequencer_tb.sv
`timescale 1ns/1ps
module adc_sdo_sequencer_tb;

    localparam int W    = 12;
    localparam int HALF = 6;

    typedef struct packed {
        logic         idle_hi;
        logic [W-1:0] word;
        logic [W-1:0] alt;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{1'b0, 12'hA5C, 12'h5A3},
        '{1'b1, 12'hA5C, 12'h5A3},
        '{1'b0, 12'h000, 12'hFFF},
        '{1'b1, 12'hFFF, 12'h000},
        '{1'b0, 12'h801, 12'h7FE},
        '{1'b1, 12'h001, 12'hFFE},
        '{1'b0, 12'h800, 12'h7FF},
        '{1'b1, 12'h3C7, 12'hC38}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] sample;
    logic         cs_n;
    logic         sclk;
    logic         sdo;
    logic         sdo_oe;
    int           total = 0;
    int           bad   = 0;
    bit           finished = 1'b0;

    always #4 clk = ~clk;

    adc_sdo_sequencer #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .cs_n_i   (cs_n),
        .sclk_i   (sclk),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    // {oe, data} expected after falling edge n of a frame
    function automatic logic [1:0] expect_at(input int n, input logic [W-1:0] w);
        if (n <= 1)     return 2'b00;
        if (n == 2)     return 2'b10;
        if (n <= W + 2) return {1'b1, w[W + 2 - n]};
        if (n <= 2 * W + 1) return {1'b1, w[n - W - 2]};
        return 2'b00;
    endfunction

    function automatic string tag_for(input int n);
        if (n <= 1)     return "R2 lead edge undriven";
        if (n == 2)     return "R4 null bit";
        if (n == 3)     return "R4/R5 top bit first";
        if (n <= W + 2) return "R5 downward pass";
        if (n <= 2 * W + 1) return "R6 upward repeat";
        return "R8 tail undriven";
    endfunction

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check_pins(input string req, input logic exp_oe, input logic exp_d);
        total++;
        if (sdo_oe !== exp_oe || (exp_oe && sdo !== exp_d)) begin
            bad++;
            $display("FAIL %s: got oe=%b d=%b expected oe=%b d=%b",
                     req, sdo_oe, sdo, exp_oe, exp_d);
        end
    endtask

    task automatic clock_edge(input bit idle_hi, input int n,
                              input logic [W-1:0] w, input string req);
        logic [1:0] e;
        logic [1:0] p;
        e = expect_at(n, w);
        p = expect_at(n - 1, w);
        if (!idle_hi) begin
            sclk = 1'b1;
            wait_cyc(HALF);
            check_pins("R3/R9 rising edge ignored", p[1], p[0]);
            sclk = 1'b0;
            wait_cyc(HALF);
            check_pins(req, e[1], e[0]);
        end else begin
            sclk = 1'b0;
            wait_cyc(HALF);
            check_pins(req, e[1], e[0]);
            sclk = 1'b1;
            wait_cyc(HALF);
            check_pins("R3/R9 rising edge ignored", e[1], e[0]);
        end
    endtask

    task automatic run_frame(input bit idle_hi, input logic [W-1:0] w,
                             input logic [W-1:0] alt, input int edges);
        sclk = idle_hi;
        wait_cyc(HALF);
        sample = w;
        cs_n   = 1'b0;
        wait_cyc(HALF);
        check_pins("R2 undriven after select", 1'b0, 1'b0);
        for (int n = 1; n <= edges; n++) begin
            if (n == 5) sample = alt;
            if (n > 5 && alt != w) begin
                clock_edge(idle_hi, n, w, $sformatf("%s R7", tag_for(n)));
            end else begin
                clock_edge(idle_hi, n, w, tag_for(n));
            end
        end
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        wait_cyc(HALF);
        check_pins("R1 undriven after deselect", 1'b0, 1'b0);
    endtask

    task automatic toggles_deselected(input int count);
        for (int k = 0; k < count; k++) begin
            sclk = ~sclk;
            wait_cyc(HALF);
            check_pins("R1 clocks while deselected", 1'b0, 1'b0);
        end
    endtask

    initial begin
        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sclk   = 1'b0;
        sample = '0;
        wait_cyc(5);
        check_pins("R11 in reset", 1'b0, 1'b0);
        total++;
        if (sdo !== 1'b0) begin
            bad++;
            $display("FAIL R11 data in reset: got %b expected 0", sdo);
        end
        rst_n = 1'b1;
        wait_cyc(3);
        check_pins("R11 after reset", 1'b0, 1'b0);

        toggles_deselected(4);

        // Table of frames, both idle polarities (R9)
        for (int i = 0; i < 8; i++) begin
            run_frame(VECS[i].idle_hi, VECS[i].word, VECS[i].alt, 28);
            end_frame();
        end

        // R10: abort mid-frame, then a fresh frame restarts at edge 1
        run_frame(1'b1, 12'h6B2, 12'h6B2, 9);
        end_frame();
        toggles_deselected(4);
        run_frame(1'b1, 12'h94D, 12'h94D, 6);
        end_frame();

        // R10: deselect and falling edge in the same instant
        run_frame(1'b0, 12'hC35, 12'hC35, 5);
        sclk = 1'b1;
        wait_cyc(HALF);
        sclk = 1'b0;
        cs_n = 1'b1;
        wait_cyc(HALF);
        check_pins("R10 abort beats coincident edge", 1'b0, 1'b0);
        wait_cyc(HALF);
        check_pins("R10 stays undriven", 1'b0, 1'b0);
        run_frame(1'b0, 12'h2D4, 12'h2D4, 4);
        end_frame();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule